// File: doc/BRIEF.md
# Predicated 64-bit Right Shifter

This execution unit shifts a 64-bit operand to the right in one clocked stage. It has two modes. The arithmetic mode copies the sign bit into the vacated upper positions. The logical mode fills those positions with zeroes. The shift amount comes from one of two places:

- a full 64-bit register operand, treated as unsigned, which saturates once it reaches 64;
- a 6-bit immediate, which never saturates.

Every operand carries a deferred-exception tag bit. The result tag is the merge of the tags the selected form actually consumes.

A qualifying predicate decides whether the destination is written. The result and its tag are computed whatever the predicate is. The write strobe, the result and the tag are all registered. They appear one clock after the operands are presented.

Top module: `shr_unit`

## Requirements
- R1: All outputs are registered, with a latency of one clock from the operands to the result. While `rstN` is low, `resVal`, `resNat` and `wrEn` are all zero.
- R2: In logical mode (`isSigned`=0) with a count n below 64, `resVal` is `srcVal` shifted right by n, with zeroes in the top n bits.
- R3: In arithmetic mode (`isSigned`=1) with a count n below 64, `resVal` is `srcVal` shifted right by n, with the top n bits equal to `srcVal[63]`.
- R4: In register form (`useImm`=0), the count is all 64 bits of `cntVal` taken as unsigned. Any set bit in positions 63..6 makes the count 64 or more, whatever the low six bits hold.
- R5: In logical register form, a count of 64 or more gives an all-zero `resVal`.
- R6: In arithmetic register form, a count of 64 or more is clamped to 63. `resVal` is then every bit equal to `srcVal[63]`.
- R7: In immediate form (`useImm`=1), the count is `immCnt` (0..63). `cntVal` and `cntNat` have no effect on `resVal` or `resNat`, and `resNat` equals `srcNat`.
- R8: In register form, `resNat` is `srcNat` OR `cntNat`.
- R9: `wrEn` is `qualPred` delayed by one clock. `resVal` and `resNat` are produced even when `qualPred` is 0.
- R10: A count of zero returns `srcVal` unchanged in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcVal | input | 64 | Value to be shifted |
| srcNat | input | 1 | Deferred-exception tag of the shifted value |
| cntVal | input | 64 | Register-supplied shift count |
| cntNat | input | 1 | Deferred-exception tag of the count register |
| immCnt | input | 6 | Immediate shift count |
| useImm | input | 1 | 1 selects the immediate count, 0 the register count |
| isSigned | input | 1 | 1 for arithmetic shift, 0 for logical |
| qualPred | input | 1 | Qualifying predicate gating the write |
| resVal | output | 64 | Shifted result |
| resNat | output | 1 | Result tag |
| wrEn | output | 1 | Destination write strobe |

## Verification
The following properties are checked on every clock:

- tag merging in both forms;
- the predicate-to-write-strobe delay;
- both saturation outcomes;
- identity at a zero count;
- the reset values.

Fill correctness at intermediate counts cannot be shown by a property. The same holds for how the count is chosen between immediate and register. The bench's scenarios cover these against a reference model: randomized operands, and counts at 0, 63, 64, huge values with small low bits, and immediate operations with a noisy count register.

// File: rtl/shr_pkg.sv
package shr_pkg;
  parameter int DATA_W = 64;
  parameter int CNT_W  = $clog2(DATA_W);

  typedef struct packed {
    logic arith;      // fill vacated bits with the sign
    logic saturate;   // count reached DATA_W or beyond
    logic useCntTag;  // count operand tag takes part in merge
  } shrStrobes_t;
endpackage

// File: rtl/shr_ctrl.sv
module shr_ctrl
  import shr_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CNT_W
) (
  input  logic [DW-1:0] cntVal,
  input  logic [CW-1:0] immCnt,
  input  logic          useImm,
  input  logic          isSigned,
  output shrStrobes_t   strobes,
  output logic [CW-1:0] effCnt
);
  localparam int HI_W = DW - CW;

  logic hiBitsSet;

  // Any set bit above the low count field means the value is >= DW.
  assign hiBitsSet = |cntVal[DW-1:CW];

  always_comb begin
    strobes.arith     = isSigned;
    strobes.saturate  = !useImm && hiBitsSet;
    strobes.useCntTag = !useImm;
    effCnt            = useImm ? immCnt : cntVal[CW-1:0];
  end

  // Width sanity check at elaboration.
  initial begin
    if (HI_W < 1) $error("count field too wide for data");
  end
endmodule

// File: rtl/shr_datapath.sv
module shr_datapath
  import shr_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CNT_W
) (
  input  logic [DW-1:0] srcVal,
  input  logic          srcNat,
  input  logic          cntNat,
  input  logic [CW-1:0] effCnt,
  input  shrStrobes_t   strobes,
  output logic [DW-1:0] shiftOut,
  output logic          natOut
);
  logic          fillBit;
  logic [DW-1:0] stage [CW+1];

  assign fillBit  = strobes.arith & srcVal[DW-1];
  assign stage[0] = srcVal;

  // Logarithmic shifter: stage i moves by 2**i when count bit i is set.
  for (genvar i = 0; i < CW; i++) begin : g_stage
    localparam int AMT = 1 << i;
    assign stage[i+1] = effCnt[i]
                      ? {{AMT{fillBit}}, stage[i][DW-1:AMT]}
                      : stage[i];
  end

  // Signed clamp to DW-1 and unsigned zeroing both reduce to all fill bits.
  assign shiftOut = strobes.saturate ? {DW{fillBit}} : stage[CW];
  assign natOut   = srcNat | (strobes.useCntTag & cntNat);
endmodule

// File: rtl/shr_unit.sv
module shr_unit
  import shr_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] srcVal,
  input  logic          srcNat,
  input  logic [DW-1:0] cntVal,
  input  logic          cntNat,
  input  logic [CW-1:0] immCnt,
  input  logic          useImm,
  input  logic          isSigned,
  input  logic          qualPred,
  output logic [DW-1:0] resVal,
  output logic          resNat,
  output logic          wrEn
);
  shrStrobes_t   strobes;
  logic [CW-1:0] effCnt;
  logic [DW-1:0] shiftOut;
  logic          natOut;
  logic          pastValid;

  shr_ctrl #(.DW(DW), .CW(CW)) u_ctrl (
    .cntVal  (cntVal),
    .immCnt  (immCnt),
    .useImm  (useImm),
    .isSigned(isSigned),
    .strobes (strobes),
    .effCnt  (effCnt)
  );

  shr_datapath #(.DW(DW), .CW(CW)) u_dp (
    .srcVal  (srcVal),
    .srcNat  (srcNat),
    .cntNat  (cntNat),
    .effCnt  (effCnt),
    .strobes (strobes),
    .shiftOut(shiftOut),
    .natOut  (natOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resVal    <= '0;
      resNat    <= 1'b0;
      wrEn      <= 1'b0;
      pastValid <= 1'b0;
    end else begin
      resVal    <= shiftOut;
      resNat    <= natOut;
      wrEn      <= qualPred;
      pastValid <= 1'b1;
    end
  end

  // R1: reset clears the outputs.
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (!rstN -> (resVal == '0 && !resNat && !wrEn)));

  // R8: register-form tag merge.
  p_tag_merge_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!useImm) |=> (!pastValid || resNat == ($past(srcNat) | $past(cntNat))));

  // R7: immediate form ignores the count tag.
  p_imm_tag_r7: assert property (@(posedge clk) disable iff (!rstN)
    useImm |=> (!pastValid || resNat == $past(srcNat)));

  // R9: predicate reaches the write strobe one clock later.
  p_wren_delay_r9: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> wrEn == $past(qualPred));

  // R5: logical saturation zeroes the result.
  p_zero_sat_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!useImm && !isSigned && |cntVal[DW-1:CW]) |=> (!pastValid || resVal == '0));

  // R6: arithmetic saturation replicates the sign.
  p_sign_sat_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!useImm && isSigned && |cntVal[DW-1:CW])
      |=> (!pastValid || resVal == {DW{$past(srcVal[DW-1])}}));

  // R10: zero count is identity.
  p_zero_count_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((useImm && immCnt == '0) || (!useImm && cntVal == '0))
      |=> (!pastValid || resVal == $past(srcVal)));
endmodule

// File: tb/shr_unit_tb.sv
module shr_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] srcVal = '0;
  logic        srcNat = 1'b0;
  logic [63:0] cntVal = '0;
  logic        cntNat = 1'b0;
  logic [5:0]  immCnt = '0;
  logic        useImm = 1'b0;
  logic        isSigned = 1'b0;
  logic        qualPred = 1'b0;
  logic [63:0] resVal;
  logic        resNat;
  logic        wrEn;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  shr_unit u_dut (
    .clk(clk), .rstN(rstN), .srcVal(srcVal), .srcNat(srcNat),
    .cntVal(cntVal), .cntNat(cntNat), .immCnt(immCnt), .useImm(useImm),
    .isSigned(isSigned), .qualPred(qualPred),
    .resVal(resVal), .resNat(resNat), .wrEn(wrEn)
  );

  function automatic logic [63:0] refVal(logic [63:0] s, logic [63:0] c,
                                         logic [5:0] im, logic ui, logic sg);
    logic [63:0] n;
    n = ui ? {58'd0, im} : c;
    if (sg) begin
      if (n > 64'd63) n = 64'd63;
      return $signed(s) >>> n;
    end
    return (n > 64'd63) ? 64'd0 : (s >> n);
  endfunction

  function automatic logic refNat(logic sn, logic cn, logic ui);
    return ui ? sn : (sn | cn);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic runOp(string req, logic [63:0] s, logic sn, logic [63:0] c,
                       logic cn, logic [5:0] im, logic ui, logic sg, logic qp);
    @(negedge clk);
    srcVal = s; srcNat = sn; cntVal = c; cntNat = cn;
    immCnt = im; useImm = ui; isSigned = sg; qualPred = qp;
    @(negedge clk);
    chk({req, " value"}, resVal, refVal(s, c, im, ui, sg));
    chk({req, " tag"}, {63'd0, resNat}, {63'd0, refNat(sn, cn, ui)});
    chk({req, " wren"}, {63'd0, wrEn}, {63'd0, qp});
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    srcVal = 64'hFFFF_0000_1234_5678; qualPred = 1'b1; srcNat = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset value", resVal, 64'd0);
    chk("R1 reset tag/wren", {62'd0, resNat, wrEn}, 64'd0);
    rstN = 1'b1;

    // Directed corners
    runOp("R10 zero count logical", 64'h8123_4567_89AB_CDEF, 0, 0, 0, 0, 0, 0, 1);
    runOp("R10 zero count arith imm", 64'h8123_4567_89AB_CDEF, 0, 0, 0, 0, 1, 1, 1);
    runOp("R2 logical 63", 64'h8000_0000_0000_0001, 0, 63, 0, 0, 0, 0, 1);
    runOp("R3 arith 63 neg", 64'h8000_0000_0000_0000, 0, 63, 0, 0, 0, 1, 1);
    runOp("R3 arith 4 neg", 64'hF0F0_0000_0000_0000, 0, 4, 0, 0, 0, 1, 1);
    runOp("R5 logical 64", 64'hFFFF_FFFF_FFFF_FFFF, 0, 64, 0, 0, 0, 0, 1);
    runOp("R6 arith 64 neg", 64'h8000_0000_0000_0000, 0, 64, 0, 0, 0, 1, 1);
    runOp("R6 arith huge pos", 64'h7FFF_FFFF_FFFF_FFFF, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 1, 1);
    runOp("R4 high bit low 1", 64'hDEAD_BEEF_0000_FFFF, 0, 64'h8000_0000_0000_0001, 0, 0, 0, 0, 1);
    runOp("R4 bit6 only arith", 64'hC000_0000_0000_0000, 0, 64'h40, 0, 0, 0, 1, 1);
    runOp("R7 imm ignores cnt", 64'hF000_0000_0000_0000, 0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 8, 1, 0, 1);
    runOp("R7 imm tag src", 64'h1234, 1, 64'h3, 1, 2, 1, 1, 1);
    runOp("R8 cnt tag only", 64'h1234, 0, 64'h3, 1, 0, 0, 0, 1);
    runOp("R8 both tags clear", 64'h1234, 0, 64'h3, 0, 0, 0, 0, 1);
    runOp("R9 pred off", 64'hABCD_0000_0000_0000, 0, 12, 1, 0, 0, 1, 0);

    // Randomized mix
    for (int k = 0; k < 400; k++) begin
      logic [63:0] s, c;
      int mode;
      s = {$urandom, $urandom};
      mode = $urandom_range(0, 3);
      case (mode)
        0: c = 64'($urandom_range(0, 63));
        1: c = {$urandom, $urandom};
        2: c = 64'($urandom_range(64, 200));
        default: c = ({$urandom, $urandom} & 64'hFFFF_FFFF_FFFF_FFC0)
                     | 64'($urandom_range(0, 63));
      endcase
      runOp("R2/R3/R4/R5/R6/R7/R8/R9 random", s, 1'($urandom), c, 1'($urandom),
            6'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule